// File: doc/BRIEF.md
# Double-Data-Rate Pin Loopback Divider

This block takes an unsigned operand pair from a shared pad bus in one clock cycle and returns their quotient and remainder on that same bus in the next cycle. The word on the bus at the rising clock edge is the numerator. The word at the falling edge of the same cycle is the denominator. A divider with a single register stage produces both results. A double-data-rate launch stage then puts the quotient on the bus while the clock is high and the remainder while the clock is low.

The pad buffer sits at the chip edge, so the block exposes the pad as three signals: the received value, the value to drive and a driver enable. The enable follows a host output-enable input that is registered on the rising edge. Operand cycles and result cycles therefore alternate under host control, and only one side drives the pins at any time. A build-time option holds the driver off for an extra half cycle after the enable rises. This gives a preamble slot before the first driven half.

Top module: `ddr_div_loop`

## Requirements
- R1: The pad bus, both operands and both results are `DW` bits wide (default 8), and all are treated as unsigned.
- R2: The pad value sampled at a rising clock edge is the numerator. The value sampled at the following falling edge is the denominator of the same pair.
- R3: For a non-zero denominator, the quotient is the unsigned integer quotient and the remainder is `num mod den`. The remainder is always less than the denominator.
- R4: Results appear exactly one clock cycle after their operand cycle. `pad_out` carries the quotient while `clk` is high and the remainder while `clk` is low.
- R5: With a zero denominator, the quotient is all ones and the remainder equals the numerator.
- R6: `pad_oe` is the value of `oe` registered at the rising edge. While `oe` was low at the last rising edge, `pad_oe` is low in both halves, and a value driven on the pins from outside reaches the operand capture unchanged.
- R7: During synchronous reset (active-high `rst`), `pad_oe` is low and both result halves on `pad_out` are zero.
- R8: With `HALF_DELAY=1`, after `oe` is first registered high, `pad_oe` stays low through the high half of the clock and rises at the falling edge. It still drops at the rising edge that registers `oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges carry data |
| rst | input | 1 | Synchronous active-high reset |
| oe | input | 1 | Host request to drive results on the pads |
| pad_in | input | DW | Value received from the pads |
| pad_out | output | DW | Value to drive: quotient when clk high, remainder when clk low |
| pad_oe | output | 1 | Pad driver enable |

## Verification
The hardest situation to reach is the bus turnaround. The host's drive and the block's drive must meet without overlap, and results must land in the exact half cycle that follows the operand cycle. The bench models the external driver. It drives the numerator and denominator in successive halves, then releases the pins before the rising edge that registers `oe` high. It checks for contention at every half and reads both result halves. A second instance built with the half-cycle delay shares the same bus, so the preamble timing is observed in the very cycles where the other instance drives.

// File: rtl/ddr_div_pkg.sv
package ddr_div_pkg;
  // default pad / operand width
  parameter int unsigned DDR_DW_DEF = 8;

  // which half of the clock a launched word occupies
  typedef enum logic {
    HALF_LOW  = 1'b0,
    HALF_HIGH = 1'b1
  } half_e;
endpackage

// File: rtl/ddr_capture.sv
module ddr_capture #(
  parameter int unsigned DW = ddr_div_pkg::DDR_DW_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] pad_in,
  output logic [DW-1:0] num_o,
  output logic [DW-1:0] den_o
);
  // rising edge: first word of the pair
  always_ff @(posedge clk) begin
    if (rst) num_o <= '0;
    else     num_o <= pad_in;
  end

  // falling edge: second word of the pair
  always_ff @(negedge clk) begin
    if (rst) den_o <= '0;
    else     den_o <= pad_in;
  end
endmodule

// File: rtl/udiv_stage.sv
module udiv_stage #(
  parameter int unsigned DW = ddr_div_pkg::DDR_DW_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic [DW-1:0] quo_o,
  output logic [DW-1:0] rem_o
);
  localparam int unsigned PW = 2 * DW;

  logic [DW-1:0] quo_c, rem_c;

  always_comb begin
    if (den_i == '0) begin
      quo_c = '1;
      rem_c = num_i;
    end else begin
      quo_c = num_i / den_i;
      rem_c = num_i % den_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_o <= '0;
      rem_o <= '0;
    end else begin
      quo_o <= quo_c;
      rem_o <= rem_c;
    end
  end

  // R5
  zero_den_chk: assert property (@(posedge clk) disable iff (rst)
    (den_i == '0) |=> (quo_o == '1) && (rem_o == $past(num_i)));

  // R3
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (den_i != '0) |=> (rem_o < $past(den_i)));

  // R3
  rebuild_chk: assert property (@(posedge clk) disable iff (rst)
    (den_i != '0) |=>
      ((PW'(quo_o) * PW'($past(den_i)) + PW'(rem_o)) == PW'($past(num_i))));
endmodule

// File: rtl/ddr_launch.sv
module ddr_launch #(
  parameter int unsigned DW         = ddr_div_pkg::DDR_DW_DEF,
  parameter bit          HALF_DELAY = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          oe_in,
  input  logic [DW-1:0] quo_i,
  input  logic [DW-1:0] rem_i,
  output logic [DW-1:0] pad_out,
  output logic          pad_oe
);
  import ddr_div_pkg::*;

  logic  oe_q;
  half_e half;

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= oe_in;
  end

  assign half    = half_e'(clk);
  assign pad_out = (half == HALF_HIGH) ? quo_i : rem_i;

  generate
    if (HALF_DELAY) begin : g_delay
      logic oe_n;
      always_ff @(negedge clk) begin
        if (rst) oe_n <= 1'b0;
        else     oe_n <= oe_q;
      end
      assign pad_oe = oe_q & oe_n;
    end else begin : g_direct
      assign pad_oe = oe_q;
    end
  endgenerate

  // R6
  no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_in |=> !pad_oe);

  // R7
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !pad_oe);
endmodule

// File: rtl/ddr_div_loop.sv
module ddr_div_loop #(
  parameter int unsigned DW         = ddr_div_pkg::DDR_DW_DEF,
  parameter bit          HALF_DELAY = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          oe,
  input  logic [DW-1:0] pad_in,
  output logic [DW-1:0] pad_out,
  output logic          pad_oe
);
  logic [DW-1:0] num, den, quo, rem;

  ddr_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .pad_in(pad_in), .num_o(num), .den_o(den)
  );

  udiv_stage #(.DW(DW)) u_div (
    .clk(clk), .rst(rst), .num_i(num), .den_i(den), .quo_o(quo), .rem_o(rem)
  );

  ddr_launch #(.DW(DW), .HALF_DELAY(HALF_DELAY)) u_out (
    .clk(clk), .rst(rst), .oe_in(oe), .quo_i(quo), .rem_i(rem),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: tb/sim_ddr_div_loop.sv
module sim_ddr_div_loop;
  localparam int CLK_P = 10;
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          oe  = 1'b0;
  logic          tb_en = 1'b0;
  logic [DW-1:0] tb_drv = '0;
  logic [DW-1:0] bus;
  logic [DW-1:0] out0, out1;
  logic          oe0, oe1;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  // pad model: the block's driver or the host's driver
  assign bus = oe0 ? out0 : (tb_en ? tb_drv : '0);

  ddr_div_loop #(.DW(DW), .HALF_DELAY(1'b0)) u0 (
    .clk(clk), .rst(rst), .oe(oe), .pad_in(bus), .pad_out(out0), .pad_oe(oe0)
  );

  ddr_div_loop #(.DW(DW), .HALF_DELAY(1'b1)) u1 (
    .clk(clk), .rst(rst), .oe(oe), .pad_in(bus), .pad_out(out1), .pad_oe(oe1)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // contention monitor (R6): never both drivers on at once
  always @(clk) begin
    #2;
    if (!rst && tb_en && oe0) begin
      fails++;
      $display("FAIL R6 contention actual=1 expected=0 at %0t", $time);
    end
  end

  // one operand cycle then one result cycle; checks both halves on both instances
  task automatic run_pair(logic [DW-1:0] n, logic [DW-1:0] d);
    logic [DW-1:0] eq, er;
    eq = (d == 0) ? '1 : n / d;
    er = (d == 0) ? n  : n % d;
    @(negedge clk); #1 tb_en = 1; tb_drv = n; oe = 0;
    @(posedge clk); #1 tb_drv = d; oe = 1;          // R2 numerator taken at rise
    @(negedge clk); #1 tb_en = 0;                   // R2 denominator taken at fall
    @(posedge clk); #1 oe = 0;
    #1;
    chk("R4 quotient high half", out0, eq);
    chk("R6 pad_oe high half", {7'b0, oe0}, 8'd1);
    chk("R8 delayed oe high half", {7'b0, oe1}, 8'd0);
    @(negedge clk); #2;
    chk("R4 remainder low half", out0, er);
    chk("R8 delayed oe low half", {7'b0, oe1}, 8'd1);
    chk("R8 remainder on delayed", out1, er);
  endtask

  task automatic t_reset();
    @(negedge clk); #2;
    chk("R7 oe in reset", {7'b0, oe0}, 8'd0);
    chk("R7 low half in reset", out0, 8'd0);
    @(posedge clk); #2;
    chk("R7 high half in reset", out0, 8'd0);
    chk("R7 delayed oe in reset", {7'b0, oe1}, 8'd0);
  endtask

  task automatic t_basic();
    run_pair(8'd100, 8'd7);    // R3
    run_pair(8'd255, 8'd16);   // R1 full-scale numerator
    run_pair(8'd5,   8'd9);    // R3 quotient zero
    run_pair(8'd200, 8'd200);  // R3 equal operands
    run_pair(8'd255, 8'd1);    // R1 unit divisor
    run_pair(8'd129, 8'd255);  // R1 unsigned top bit
  endtask

  task automatic t_divzero();
    run_pair(8'd77,  8'd0);    // R5
    run_pair(8'd0,   8'd0);    // R5
    run_pair(8'd255, 8'd0);    // R5
  endtask

  task automatic t_sweep();
    for (int n = 0; n < 256; n += 37)
      for (int d = 0; d < 256; d += 23)
        run_pair(DW'(n), DW'(d));  // R3 / R5 sweep
  endtask

  task automatic t_oe_off();
    // operand cycle with oe held low; next cycle stays host-driven
    @(negedge clk); #1 tb_en = 1; tb_drv = 8'hA5; oe = 0;
    @(posedge clk); #1 tb_drv = 8'h3C;
    @(negedge clk); #1 tb_drv = 8'h5A;
    @(posedge clk); #2;
    chk("R6 no drive high half", {7'b0, oe0}, 8'd0);
    chk("R6 bus keeps host value", bus, 8'h5A);
    @(negedge clk); #2;
    chk("R6 no drive low half", {7'b0, oe0}, 8'd0);
    // the host value reached the capture: it returns as the next results
    @(negedge clk); #1 tb_drv = 8'd90; oe = 0;
    @(posedge clk); #1 tb_drv = 8'd9; oe = 1;
    @(negedge clk); #1 tb_en = 0;
    @(posedge clk); #1 oe = 0; #1;
    chk("R6 capture after idle quotient", out0, 8'd10);
    @(negedge clk); #2;
    chk("R6 capture after idle remainder", out0, 8'd0);
    @(posedge clk); #2;
    chk("R8 delayed oe drops at rise", {7'b0, oe1}, 8'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(posedge clk); #1 rst = 0;
    t_basic();
    t_divzero();
    t_sweep();
    t_oe_off();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_P * 100000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule